// File: doc/BRIEF.md
# I3C Cluster Global Configuration and Address Decoder

This block is the shared front end for a group of six I3C controllers. It answers a simple 32-bit register bus over a 32 KB address space. The bottom of that space holds a small file of word registers. Each controller owns two words in that file. The second word of each pair carries the controller's bus mode, its static target address, the enable for that address and an instance number.

The block stores a write to any such configuration word only if the resulting word keeps both the legacy two-wire mode bit and the static-address enable bit clear. A write that would set either bit leaves the register unchanged and raises a one-cycle reject pulse. Every other word in the file takes writes unchanged, honouring the byte strobes.

Above the register file sit six 4 KB windows, one for each controller. An access that falls in a window is passed to that controller's downstream port. The block raises that port's select, hands over the offset within the window, and returns the port's read data. Addresses that fall in neither the register file nor a window read zero, and writes to them are ignored.

Top module: `i3cg_top`

## Requirements
- R1: After synchronous reset every register-file word reads 0, and neither `rsp_valid` nor `rej_pulse` is high.
- R2: A read request (`req_valid`=1, `req_write`=0) is answered at the next clock edge. From that edge `rsp_valid` is 1 for one cycle and `rsp_rdata` holds the 32-bit word at byte address `req_addr` with the low two address bits ignored. The register file covers byte addresses 0x000 to 0x07F.
- R3: A write to any register-file word other than a configuration word is stored unchanged. This covers the first word of each controller pair. Byte lane i (`req_wstrb[i]`) updates bits 8i+7:8i, and bytes with a clear strobe keep their old value.
- R4: Controller k (k = 1..6) has its configuration word at byte address k*0x10+4, with these fields: bit 0 two-wire legacy mode, bit 1 target test flag, bits 3:2 activity mode, bits 7:4 pending interrupts, bits 14:8 static address, bit 15 static-address enable, bits 19:16 instance number. A write whose resulting word has bit 0 set is discarded, and the register keeps its previous value.
- R5: A write to a configuration word whose resulting word has bit 15 set is discarded, even when bit 0 is clear.
- R6: For a write with partial strobes, the discard test applies to the word formed by merging the strobed bytes into the current value. A set bit in an unstrobed lane of the write data has no effect.
- R7: `rej_pulse` is 1 for exactly the one cycle after a discarded write, and 0 after every accepted write and every read.
- R8: Controller n (n = 0..5) owns byte addresses 0x2000+n*0x1000 to 0x2FFF+n*0x1000. While a request is in that window, only `port_sel[n]` is 1 and `port_off` equals the address minus the window base. `port_write`, `port_wdata` and `port_wstrb` follow the request, and the read response carries that port's `port_rdata` slice.
- R9: For an address in 0x080 to 0x1FFF, no port select is raised, a read returns 0, and a write changes no register and raises no reject pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address within the 32 KB space |
| req_wdata | input | 32 | Write data, little-endian |
| req_wstrb | input | 4 | Byte write strobes |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| rej_pulse | output | 1 | One-cycle pulse after a discarded configuration write |
| port_sel | output | 6 | One-hot downstream port select, combinational |
| port_write | output | 1 | Downstream write enable |
| port_off | output | 12 | Offset within the selected window |
| port_wdata | output | 32 | Downstream write data |
| port_wstrb | output | 4 | Downstream byte strobes |
| port_rdata | input | 192 | Read data of the six ports, port n in bits 32n+31:32n |

## Verification
The downstream select, offset and write signals are combinational, so the driver checks them one time unit after it applies a request, in the same cycle. The read response and the reject pulse are each one register deep, so they are due from the edge that samples the request. The driver pushes each expected read word into a scoreboard queue, and a monitor pops and compares it at the falling edge after that. The driver samples the reject pulse just after that same edge.

// File: rtl/i3cg_pkg.sv
package i3cg_pkg;
    parameter int ADDR_W     = 15;
    parameter int DATA_W     = 32;
    parameter int STRB_W     = DATA_W / 8;
    parameter int N_CTRL     = 6;
    parameter int WIN_W      = 12;
    parameter int PORT_FIRST = 2;
    parameter int GLB_WORDS  = 32;
    parameter int WIDX_W     = ADDR_W - 2;
    parameter int PIDX_W     = $clog2(N_CTRL);
    parameter int BLK_W      = ADDR_W - WIN_W;
    parameter int BIT_LEGACY = 0;
    parameter int BIT_SAEN   = 15;

    typedef enum logic [1:0] {
        RG_HOLE   = 2'd0,
        RG_GLOBAL = 2'd1,
        RG_PORT   = 2'd2
    } region_e;

    typedef struct packed {
        region_e               region;
        logic [PIDX_W-1:0]     port;
        logic [WIDX_W-1:0]     widx;
        logic [WIN_W-1:0]      off;
    } decode_t;

    function automatic logic is_cfg_word(input logic [WIDX_W-1:0] widx);
        logic [WIDX_W-1:0] grp;
        grp = widx >> 2;
        return (widx[1:0] == 2'd1) && (grp >= 1) && (grp <= WIDX_W'(N_CTRL));
    endfunction

    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [STRB_W-1:0] strb);
        logic [DATA_W-1:0] res;
        for (int i = 0; i < STRB_W; i++) begin
            res[8*i +: 8] = strb[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
        end
        return res;
    endfunction
endpackage

// File: rtl/i3cg_decode.sv
module i3cg_decode
    import i3cg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam logic [BLK_W-1:0] FIRST_BLK = BLK_W'(PORT_FIRST);
    localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(PORT_FIRST + N_CTRL - 1);

    logic [BLK_W-1:0]  blk;
    logic [WIDX_W-1:0] widx;

    assign blk  = addr[ADDR_W-1:WIN_W];
    assign widx = addr[ADDR_W-1:2];

    always_comb begin
        dec.widx   = widx;
        dec.off    = addr[WIN_W-1:0];
        dec.port   = '0;
        dec.region = RG_HOLE;
        if (blk >= FIRST_BLK && blk <= LAST_BLK) begin
            dec.region = RG_PORT;
            dec.port   = PIDX_W'(blk - FIRST_BLK);
        end else if (blk < FIRST_BLK && widx < WIDX_W'(GLB_WORDS)) begin
            dec.region = RG_GLOBAL;
        end
    end
endmodule

// File: rtl/i3cg_regfile.sv
module i3cg_regfile
    import i3cg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic [DATA_W-1:0] rd_word,
    output logic              wr_reject
);
    localparam int FIDX_W = $clog2(GLB_WORDS);

    logic [DATA_W-1:0] words [GLB_WORDS];
    logic [FIDX_W-1:0] fidx;
    logic [DATA_W-1:0] merged;

    assign fidx    = widx[FIDX_W-1:0];
    assign rd_word = words[fidx];
    assign merged  = merge_bytes(words[fidx], wdata, wstrb);

    always_comb begin
        wr_reject = 1'b0;
        if (wr_en && is_cfg_word(widx) && (merged[BIT_LEGACY] || merged[BIT_SAEN])) begin
            wr_reject = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GLB_WORDS; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en && !wr_reject) begin
            words[fidx] <= merged;
        end
    end
endmodule

// File: rtl/i3cg_top.sv
module i3cg_top
    import i3cg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [STRB_W-1:0]        req_wstrb,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     rej_pulse,
    output logic [N_CTRL-1:0]        port_sel,
    output logic                     port_write,
    output logic [WIN_W-1:0]         port_off,
    output logic [DATA_W-1:0]        port_wdata,
    output logic [STRB_W-1:0]        port_wstrb,
    input  logic [N_CTRL*DATA_W-1:0] port_rdata
);
    decode_t           dec;
    logic              glb_wr;
    logic              glb_rej;
    logic [DATA_W-1:0] glb_rd;
    logic [DATA_W-1:0] rd_mux;

    i3cg_decode u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    assign glb_wr = req_valid && req_write && (dec.region == RG_GLOBAL);

    i3cg_regfile u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (glb_wr),
        .widx      (dec.widx),
        .wdata     (req_wdata),
        .wstrb     (req_wstrb),
        .rd_word   (glb_rd),
        .wr_reject (glb_rej)
    );

    for (genvar n = 0; n < N_CTRL; n++) begin : g_sel
        assign port_sel[n] = req_valid && (dec.region == RG_PORT) &&
                             (dec.port == PIDX_W'(n));
    end

    assign port_write = req_write;
    assign port_off   = dec.off;
    assign port_wdata = req_wdata;
    assign port_wstrb = req_wstrb;

    always_comb begin
        case (dec.region)
            RG_GLOBAL: rd_mux = glb_rd;
            RG_PORT:   rd_mux = port_rdata[DATA_W*dec.port +: DATA_W];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rej_pulse <= 1'b0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rej_pulse <= glb_rej;
            if (req_valid && !req_write) begin
                rsp_rdata <= rd_mux;
            end
        end
    end
endmodule

// File: rtl/i3cg_checker.sv
module i3cg_checker
    import i3cg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              rej_pulse,
    input logic [N_CTRL-1:0] port_sel
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !rej_pulse));

    p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    p_rej_after_write_r7: assert property (@(posedge clk) disable iff (rst)
        rej_pulse |-> $past(req_valid && req_write));

    p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_sel));

    p_sel_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        (|port_sel) |-> req_valid);

    p_no_rsp_rej_same_r7: assert property (@(posedge clk) disable iff (rst)
        rej_pulse |-> !rsp_valid);
endmodule

bind i3cg_top i3cg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rej_pulse (rej_pulse),
    .port_sel  (port_sel)
);

// File: tb/tb_i3cg_top.sv
module tb_i3cg_top;
    import i3cg_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     req_valid = 1'b0;
    logic                     req_write = 1'b0;
    logic [ADDR_W-1:0]        req_addr = '0;
    logic [DATA_W-1:0]        req_wdata = '0;
    logic [STRB_W-1:0]        req_wstrb = '0;
    logic                     rsp_valid;
    logic [DATA_W-1:0]        rsp_rdata;
    logic                     rej_pulse;
    logic [N_CTRL-1:0]        port_sel;
    logic                     port_write;
    logic [WIN_W-1:0]         port_off;
    logic [DATA_W-1:0]        port_wdata;
    logic [STRB_W-1:0]        port_wstrb;
    logic [N_CTRL*DATA_W-1:0] port_rdata;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];

    logic [DATA_W-1:0] stub_reg [N_CTRL];

    always #(CLK_PERIOD/2) clk = ~clk;

    i3cg_top dut (.*);

    // Downstream stubs: one register each; read returns it XOR the offset.
    for (genvar n = 0; n < N_CTRL; n++) begin : g_stub
        assign port_rdata[DATA_W*n +: DATA_W] = stub_reg[n] ^ {20'h0, port_off};
        always_ff @(posedge clk) begin
            if (rst) stub_reg[n] <= 32'hA000_0000 + 32'(n) * 32'h0100_0000;
            else if (port_sel[n] && port_write) stub_reg[n] <= port_wdata;
        end
    end

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected word per read response.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected response", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic access(input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input logic [STRB_W-1:0] s,
                          input logic exp_rej, input logic [N_CTRL-1:0] exp_sel,
                          input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_wstrb = s;
        #1;
        check({req, " sel"}, 32'(port_sel), 32'(exp_sel));
        if (exp_sel != 0) check({req, " off"}, 32'(port_off), 32'(a - ADDR_W'(12'h000) & 15'h0FFF));
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (wr) check({req, " rej"}, 32'(rej_pulse), 32'(exp_rej));
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      input logic [STRB_W-1:0] s, input logic exp_rej, input string req);
        access(1'b1, a, d, s, exp_rej, '0, req);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                      input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        access(1'b0, a, '0, '0, 1'b0, '0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        check("watchdog expired", 32'h1, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
        check("R1 rej_pulse in reset", 32'(rej_pulse), 32'h0);
        rst = 1'b0;

        rd(15'h010, 32'h0, "R1 reg0 ctrl1 zero");
        rd(15'h014, 32'h0, "R1 reg1 ctrl1 zero");
        rd(15'h07C, 32'h0, "R1 last word zero");

        wr(15'h010, 32'hDEAD_BEEF, 4'hF, 1'b0, "R3 reg0 full write");
        rd(15'h010, 32'hDEAD_BEEF, "R3 reg0 readback");
        rd(15'h013, 32'hDEAD_BEEF, "R2 low addr bits ignored");
        wr(15'h014, 32'h000A_3F5C, 4'hF, 1'b0, "R7 accepted cfg write");
        rd(15'h014, 32'h000A_3F5C, "R3 cfg accepted value");

        wr(15'h014, 32'h0000_0001, 4'hF, 1'b1, "R4 legacy bit write");
        rd(15'h014, 32'h000A_3F5C, "R4 cfg kept");
        wr(15'h024, 32'h0000_8000, 4'hF, 1'b1, "R5 saen write");
        rd(15'h024, 32'h0, "R5 cfg ctrl2 kept");
        wr(15'h034, 32'h0000_8001, 4'hF, 1'b1, "R5 both bits write");
        rd(15'h034, 32'h0, "R5 cfg ctrl3 kept");

        wr(15'h014, 32'h0000_8000, 4'h2, 1'b1, "R6 byte1 saen");
        rd(15'h014, 32'h000A_3F5C, "R6 cfg kept after byte1");
        wr(15'h014, 32'h0005_0001, 4'h4, 1'b0, "R6 lane2 only");
        rd(15'h014, 32'h0005_3F5C, "R6 merged value");

        wr(15'h020, 32'h1234_56AB, 4'h1, 1'b0, "R3 byte write reg0");
        rd(15'h020, 32'h0000_00AB, "R3 byte merge");
        wr(15'h004, 32'h0000_8001, 4'hF, 1'b0, "R3 non-cfg word");
        rd(15'h004, 32'h0000_8001, "R3 non-cfg stored");
        wr(15'h064, 32'h0003_0004, 4'hF, 1'b0, "R4 ctrl6 cfg good");
        rd(15'h064, 32'h0003_0004, "R4 ctrl6 readback");
        wr(15'h074, 32'h0000_8001, 4'hF, 1'b0, "R4 word past ctrl6 not cfg");
        rd(15'h074, 32'h0000_8001, "R4 past ctrl6 stored");

        wr(15'h080, 32'hFFFF_FFFF, 4'hF, 1'b0, "R9 gap write low");
        rd(15'h080, 32'h0, "R9 gap read low");
        wr(15'h1FFC, 32'h5555_5555, 4'hF, 1'b0, "R9 gap write high");
        rd(15'h1FFC, 32'h0, "R9 gap read high");
        rd(15'h000, 32'h0, "R9 word0 untouched");

        for (int n = 0; n < N_CTRL; n++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'(32'h2000 + n * 32'h1000 + 32'h3C);
            access(1'b1, a, 32'h1234_0000 + 32'(n), 4'hF, 1'b0,
                   N_CTRL'(1 << n), "R8 port write");
            exp_q.push_back((32'h1234_0000 + 32'(n)) ^ 32'h3C);
            tag_q.push_back("R8 port read");
            access(1'b0, a, '0, '0, 1'b0, N_CTRL'(1 << n), "R8 port read");
        end
        exp_q.push_back((32'h1234_0005) ^ 32'hFFC);
        tag_q.push_back("R8 port5 top offset");
        access(1'b0, 15'h7FFC, '0, '0, 1'b0, 6'b100000, "R8 port5 top offset");
        rd(15'h010, 32'hDEAD_BEEF, "R8 global untouched by ports");

        repeat (3) @(posedge clk);
        #1;
        check("R2 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule